// File: doc/BRIEF.md
# External Interrupt Trigger Controller

The block watches a bank of 28 asynchronous interrupt lines. Each line passes through a synchronizer. It is then judged against a trigger mode: rising edge, falling edge, either edge, low level or high level. A qualifying event latches into a per-line pending bit.

Software sees three kinds of state through a small word-addressed register bus:
- the trigger configuration, held in two words;
- a per-line mask;
- the pending bits, which are cleared by writing ones.

The unmasked pending bits merge into four group interrupt outputs of uneven size. These feed a downstream interrupt controller.

Adjacent lines are paired: lines 2k and 2k+1 always share one trigger mode. Pending capture does not depend on the mask. A line that was masked when its event arrived raises its group as soon as it is unmasked.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset:
  - every configuration field reads zero (low-level mode);
  - the mask word reads 0x0FFFFFFF;
  - the pending word reads zero;
  - all four group outputs are low.
- R2: Register addresses are 0 for the configuration of pairs 0..7, 1 for the configuration of pairs 8..13, 2 for the mask and 3 for the pending bits. The 4-bit field for line n sits at bit ((n/2)%8)*4 of configuration word n/16. Bit 3 of every field reads zero, and bits 31:24 of word 1 read zero.
- R3: Field code 10x selects rising-edge detection. A 0-to-1 input change driven between clock edges sets the pending bit readable after the third following rising clock edge, and not after the second. A 1-to-0 change sets nothing.
- R4: Field code 01x selects falling-edge detection. Only a 1-to-0 change sets the pending bit.
- R5: Field code 11x selects detection on both edges. Both members of a pair follow the one field.
- R6: Field code 000 selects low-level mode. The pending bit is set on every cycle the synchronized input is low, so a write-1 clear has no lasting effect while the input stays low.
- R7: Field code 001 selects high-level mode. The pending bit is set on every cycle the synchronized input is high.
- R8: Writing 1 to a bit of the pending word clears it. Writing 0 leaves it unchanged.
- R9: When a detected event and a clearing write hit the same line in the same cycle, the pending bit stays set.
- R10: The mask word is read-write in bits 27:0. A 1 masks the line, and bits 31:28 read zero.
- R11: Group output g is high when some line of its group has its pending bit set and its mask bit clear. The groups are: g0 for lines 0-3, g1 for lines 4-11, g2 for lines 12-19 and g3 for lines 20-27.
- R12: Pending bits capture events on masked lines. Clearing the mask bit raises the group output in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 28 | Asynchronous external interrupt lines |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable, qualified by req_i |
| addr_i | input | 2 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| grp_o | output | 4 | Group interrupt outputs |

## Verification
The assertions assume bus writes are qualified only by req_i and we_i at the sampling edge. They also assume the interrupt inputs may change at any cycle, so each property is stated against the synchronized value and not the raw pin.

The stimulus drives the bus and the lines only on falling clock edges and releases req_i after one cycle. It makes sparse random toggles on the lines and random writes to all four words, including clears that collide with level events.

Directed sequences cover the exact capture latency, each trigger code, pair sharing, masked capture followed by unmasking, and one line at each group boundary.

// File: rtl/eint_pkg.sv
package eint_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned FIELD_W = 4;
  localparam int unsigned MODE_W  = 3;

  localparam logic [1:0] ADDR_CFG0 = 2'd0;
  localparam logic [1:0] ADDR_CFG1 = 2'd1;
  localparam logic [1:0] ADDR_MASK = 2'd2;
  localparam logic [1:0] ADDR_PEND = 2'd3;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'b00,
    TRIG_FALL  = 2'b01,
    TRIG_RISE  = 2'b10,
    TRIG_BOTH  = 2'b11
  } trig_kind_e;

  // cur/prev are consecutive synchronized samples
  function automatic logic trig_hit(logic [MODE_W-1:0] mode, logic cur, logic prev);
    trig_kind_e kind;
    kind = trig_kind_e'(mode[2:1]);
    case (kind)
      TRIG_LEVEL: trig_hit = mode[0] ? cur : ~cur;
      TRIG_FALL:  trig_hit = ~cur & prev;
      TRIG_RISE:  trig_hit = cur & ~prev;
      default:    trig_hit = cur ^ prev;
    endcase
  endfunction
endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter int unsigned N = 28
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o,
  output logic [N-1:0] prev_o
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/eint_detect.sv
module eint_detect
  import eint_pkg::*;
#(
  parameter int unsigned N = 28
) (
  input  logic [N-1:0]             sync_i,
  input  logic [N-1:0]             prev_i,
  input  logic [N-1:0][MODE_W-1:0] mode_i,
  output logic [N-1:0]             evt_o
);
  for (genvar n = 0; n < N; n++) begin : g_line
    always_comb evt_o[n] = trig_hit(mode_i[n], sync_i[n], prev_i[n]);
  end
endmodule

// File: rtl/eint_regs.sv
module eint_regs
  import eint_pkg::*;
#(
  parameter int unsigned N = 28
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [1:0]               addr_i,
  input  logic [REG_W-1:0]         wdata_i,
  output logic [REG_W-1:0]         rdata_o,
  input  logic [N-1:0]             evt_i,
  output logic [N-1:0][MODE_W-1:0] mode_o,
  output logic [N-1:0]             mask_o,
  output logic [N-1:0]             pend_o
);
  localparam int unsigned NUM_PAIRS      = N / 2;
  localparam int unsigned PAIRS_PER_WORD = REG_W / FIELD_W;
  localparam int unsigned CFG_WORDS      = 2;

  logic [NUM_PAIRS-1:0][MODE_W-1:0] cfg_q;
  logic [N-1:0] mask_q, pend_q, clr;
  logic [CFG_WORDS-1:0][REG_W-1:0] cfg_rd;
  logic wr_en, wr_cfg0, wr_cfg1, wr_mask, wr_pend;

  assign wr_en   = req_i & we_i;
  assign wr_cfg0 = wr_en & (addr_i == ADDR_CFG0);
  assign wr_cfg1 = wr_en & (addr_i == ADDR_CFG1);
  assign wr_mask = wr_en & (addr_i == ADDR_MASK);
  assign wr_pend = wr_en & (addr_i == ADDR_PEND);

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam int unsigned WORD = p / PAIRS_PER_WORD;
    localparam int unsigned OFS  = (p % PAIRS_PER_WORD) * FIELD_W;
    logic sel;
    assign sel = (WORD == 0) ? wr_cfg0 : wr_cfg1;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  cfg_q[p] <= '0;
      else if (sel) cfg_q[p] <= wdata_i[OFS +: MODE_W];
    end
    assign mode_o[2*p]   = cfg_q[p];
    assign mode_o[2*p+1] = cfg_q[p];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '1;
    else if (wr_mask) mask_q <= wdata_i[N-1:0];
  end

  assign clr = wr_pend ? wdata_i[N-1:0] : '0;

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr) | evt_i;
  end

  always_comb begin
    cfg_rd = '0;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      cfg_rd[p / PAIRS_PER_WORD][(p % PAIRS_PER_WORD) * FIELD_W +: FIELD_W] = {1'b0, cfg_q[p]};
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_CFG0: rdata_o = cfg_rd[0];
      ADDR_CFG1: rdata_o = cfg_rd[1];
      ADDR_MASK: rdata_o = {{(REG_W-N){1'b0}}, mask_q};
      default:   rdata_o = {{(REG_W-N){1'b0}}, pend_q};
    endcase
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;
endmodule

// File: rtl/eint_group.sv
module eint_group #(
  parameter int unsigned FIRST_W    = 4,
  parameter int unsigned GRP_W      = 8,
  parameter int unsigned NUM_GROUPS = 4,
  localparam int unsigned N = FIRST_W + (NUM_GROUPS - 1) * GRP_W
) (
  input  logic [N-1:0]          active_i,
  output logic [NUM_GROUPS-1:0] grp_o
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int unsigned LO = (g == 0) ? 0 : FIRST_W + (g - 1) * GRP_W;
    localparam int unsigned W  = (g == 0) ? FIRST_W : GRP_W;
    assign grp_o[g] = |active_i[LO +: W];
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eint_pkg::*;
#(
  parameter int unsigned FIRST_GRP_W = 4,
  parameter int unsigned GRP_W       = 8,
  parameter int unsigned NUM_GROUPS  = 4,
  localparam int unsigned NUM_LINES  = FIRST_GRP_W + (NUM_GROUPS - 1) * GRP_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_LINES-1:0]  irq_i,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [1:0]            addr_i,
  input  logic [REG_W-1:0]      wdata_i,
  output logic [REG_W-1:0]      rdata_o,
  output logic [NUM_GROUPS-1:0] grp_o
);
  logic [NUM_LINES-1:0] line_sync, line_prev, line_evt, mask_q, pend_q;
  logic [NUM_LINES-1:0][MODE_W-1:0] line_mode;

  eint_sync #(.N(NUM_LINES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (irq_i),
    .sync_o  (line_sync),
    .prev_o  (line_prev)
  );

  eint_detect #(.N(NUM_LINES)) u_detect (
    .sync_i (line_sync),
    .prev_i (line_prev),
    .mode_i (line_mode),
    .evt_o  (line_evt)
  );

  eint_regs #(.N(NUM_LINES)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .evt_i   (line_evt),
    .mode_o  (line_mode),
    .mask_o  (mask_q),
    .pend_o  (pend_q)
  );

  eint_group #(
    .FIRST_W    (FIRST_GRP_W),
    .GRP_W      (GRP_W),
    .NUM_GROUPS (NUM_GROUPS)
  ) u_group (
    .active_i (pend_q & ~mask_q),
    .grp_o    (grp_o)
  );
endmodule

// File: rtl/eint_checker.sv
module eint_checker #(
  parameter int unsigned N  = 28,
  parameter int unsigned NG = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [1:0]        addr_i,
  input logic [31:0]       wdata_i,
  input logic [NG-1:0]     grp_o,
  input logic [N-1:0]      pend_i,
  input logic [N-1:0]      mask_i,
  input logic [N-1:0]      evt_i,
  input logic [N-1:0]      sync_i,
  input logic [N-1:0][2:0] mode_i
);
  logic wr_pend, wr_mask;
  assign wr_pend = req_i & we_i & (addr_i == 2'd3);
  assign wr_mask = req_i & we_i & (addr_i == 2'd2);

  assert_mask_gate_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_i) |-> (grp_o == '0));

  assert_grp_source_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_o != '0) |-> ((pend_i & ~mask_i) != '0));

  assert_mask_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask |=> (mask_i == $past(wdata_i[N-1:0])));

  for (genvar n = 0; n < N; n++) begin : g_line
    assert_evt_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[n] |=> pend_i[n]);

    assert_w1c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_pend && wdata_i[n] && !evt_i[n]) |=> !pend_i[n]);

    assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_i[n] && !(wr_pend && wdata_i[n])) |=> pend_i[n]);

    assert_no_spurious_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pend_i[n] && !evt_i[n]) |=> !pend_i[n]);

    assert_low_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[n] == 3'b000) |-> (evt_i[n] == !sync_i[n]));

    assert_high_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[n] == 3'b001) |-> (evt_i[n] == sync_i[n]));
  end
endmodule

bind ext_irq_ctrl eint_checker #(.N(NUM_LINES), .NG(NUM_GROUPS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .grp_o   (grp_o),
  .pend_i  (pend_q),
  .mask_i  (mask_q),
  .evt_i   (line_evt),
  .sync_i  (line_sync),
  .mode_i  (line_mode)
);

// File: tb/tb_ext_irq_ctrl.sv
module tb_ext_irq_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [27:0] irq = '0;
  logic        req = 0, we = 0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  grp;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5ns clk = ~clk;

  ext_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .grp_o(grp)
  );

  // reference model built from the requirements
  logic [27:0] m_s1, m_s2, m_p, m_mask, m_pend, m_nxt;
  logic [31:0] m_cfg0, m_cfg1;

  function automatic logic [2:0] m_field(int n);
    if (n < 16) return m_cfg0[(n/2)*4 +: 3];
    else        return m_cfg1[((n-16)/2)*4 +: 3];
  endfunction

  function automatic logic m_hit(logic [2:0] f, logic cur, logic prev);
    if (f == 3'b000)      return !cur;
    if (f == 3'b001)      return cur;
    if (f[2:1] == 2'b01)  return prev && !cur;
    if (f[2:1] == 2'b10)  return cur && !prev;
    return cur != prev;
  endfunction

  function automatic logic [3:0] m_grp(logic [27:0] act);
    return {|act[27:20], |act[19:12], |act[11:4], |act[3:0]};
  endfunction

  function automatic int grp_of(int n);
    return (n < 4) ? 0 : 1 + (n - 4) / 8;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_p <= '0;
      m_cfg0 <= '0; m_cfg1 <= '0; m_mask <= '1; m_pend <= '0;
    end else begin
      m_s1 <= irq; m_s2 <= m_s1; m_p <= m_s2;
      m_nxt = m_pend;
      if (req && we && addr == 2'd3) m_nxt = m_nxt & ~wdata[27:0];
      for (int n = 0; n < 28; n++)
        if (m_hit(m_field(n), m_s2[n], m_p[n])) m_nxt[n] = 1'b1;
      m_pend <= m_nxt;
      if (req && we && addr == 2'd0) m_cfg0 <= wdata & 32'h7777_7777;
      if (req && we && addr == 2'd1) m_cfg1 <= wdata & 32'h0077_7777;
      if (req && we && addr == 2'd2) m_mask <= wdata[27:0];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    req = 0; we = 0; addr = a;
    #1ns;
    d = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] d;
    int lines[7] = '{3, 4, 11, 12, 19, 20, 27};
    void'($urandom(32'd20240517));
    step(3);
    // R1
    rd(0, d); chk("R1 cfg0", d, 32'h0);
    rd(1, d); chk("R1 cfg1", d, 32'h0);
    rd(2, d); chk("R1 mask", d, 32'h0FFF_FFFF);
    rd(3, d); chk("R1 pend", d, 32'h0);
    chk("R1 grp", {28'h0, grp}, 32'h0);
    rst_n = 1;
    step(1);
    wr(0, 32'h4444_4444); wr(1, 32'h0044_4444);
    step(2);
    wr(3, 32'h0FFF_FFFF);
    rd(3, d); chk("R8 clear all", d, 32'h0);
    // R2
    wr(0, 32'hFFFF_FFFF); rd(0, d); chk("R2 cfg0 readback", d, 32'h7777_7777);
    wr(1, 32'hFFFF_FFFF); rd(1, d); chk("R2 cfg1 readback", d, 32'h0077_7777);
    wr(0, 32'h4444_4444); wr(1, 32'h0044_4444);
    step(3);
    rd(3, d); chk("R2 no events while stable", d, 32'h0);
    // R3 rising, exact latency
    irq[5] = 1;
    step(2); rd(3, d); chk("R3 not before third edge", d, 32'h0);
    step(1); rd(3, d); chk("R3 set at third edge", d, 32'h20);
    wr(3, 32'h0000_0000); rd(3, d); chk("R8 write zero keeps", d, 32'h20);
    wr(3, 32'h0000_0020); rd(3, d); chk("R8 write one clears", d, 32'h0);
    irq[5] = 0; step(4); rd(3, d); chk("R3 falling ignored", d, 32'h0);
    // R4 falling (pair 2 field at bits 10:8)
    wr(0, 32'h4444_4244);
    irq[5] = 1; step(4); rd(3, d); chk("R4 rising ignored", d, 32'h0);
    irq[5] = 0; step(4); rd(3, d); chk("R4 falling sets", d, 32'h20);
    wr(3, 32'h20);
    // R5 both edges, pair shares mode
    wr(0, 32'h4444_4644);
    irq[5] = 1; step(4); rd(3, d); chk("R5 rise sets", d, 32'h20);
    wr(3, 32'h20);
    irq[5] = 0; step(4); rd(3, d); chk("R5 fall sets", d, 32'h20);
    wr(3, 32'h20);
    irq[4] = 1; step(4); rd(3, d); chk("R5 pair partner line 4", d, 32'h10);
    irq[4] = 0; step(4); wr(3, 32'h30);
    rd(3, d); chk("R5 cleared", d, 32'h0);
    // R6 low level, clear loses (R9)
    wr(0, 32'h4444_4044);
    step(3); rd(3, d); chk("R6 low level sets", d, 32'h30);
    wr(3, 32'h30); rd(3, d); chk("R9 clear during event keeps", d, 32'h30);
    irq[5:4] = 2'b11; step(3); wr(3, 32'h30);
    rd(3, d); chk("R6 clear after level released", d, 32'h0);
    // R7 high level
    wr(0, 32'h4444_4144);
    step(2); wr(3, 32'h30); rd(3, d); chk("R7 high persists", d, 32'h30);
    irq[5:4] = 2'b00; step(3); wr(3, 32'h30);
    rd(3, d); chk("R7 clear after release", d, 32'h0);
    wr(0, 32'h4444_4444);
    step(3); wr(3, 32'h0FFF_FFFF);
    // R10
    wr(2, 32'hFABC_DEF0); rd(2, d); chk("R10 mask readback", d, 32'h0ABC_DEF0);
    wr(2, 32'hFFFF_FFFF); rd(2, d); chk("R10 mask all", d, 32'h0FFF_FFFF);
    // R12 masked capture then unmask
    irq[13] = 1; step(1); irq[13] = 0; step(4);
    rd(3, d); chk("R12 captured while masked", d, 32'h2000);
    chk("R12 grp low while masked", {28'h0, grp}, 32'h0);
    wr(2, ~32'h2000); chk("R12 unmask raises group", {28'h0, grp}, 32'h4);
    wr(3, 32'h2000); chk("R12 cleared drops group", {28'h0, grp}, 32'h0);
    // R11 group boundaries
    wr(2, 32'h0);
    foreach (lines[i]) begin
      irq[lines[i]] = 1; step(1); irq[lines[i]] = 0; step(4);
      chk($sformatf("R11 line %0d group", lines[i]), {28'h0, grp},
          32'(1 << grp_of(lines[i])));
      wr(3, 32'(1 << lines[i]));
    end
    // random phase against model (R11 and all modes)
    for (int it = 0; it < 600; it++) begin
      irq = irq ^ (28'($urandom) & 28'($urandom) & 28'($urandom));
      if ($urandom_range(0, 3) == 0) begin
        logic [1:0] a;
        a = 2'($urandom_range(0, 3));
        wr(a, (a == 2'd3) ? ($urandom & $urandom) : $urandom);
      end else step(1);
      rd(3, d); chk("R11 random pend", d, {4'h0, m_pend});
      chk("R11 random grp", {28'h0, grp}, {28'h0, m_grp(m_pend & ~m_mask)});
    end
    rd(0, d); chk("R2 random cfg0", d, m_cfg0);
    rd(1, d); chk("R2 random cfg1", d, m_cfg1);
    rd(2, d); chk("R10 random mask", d, {4'h0, m_mask});
    report();
  end
endmodule